// File: doc/BRIEF.md
# Dual-Reload PWM Timer

This block holds up to three independent timer channels behind one small register map. Each channel has a low-phase count, a high-phase count and a control word. When the channel runs, it drives a waveform that is low for one count and high for the other, with each phase measured in input clock cycles. It raises a sticky interrupt each time a phase expires. A register bus with write and read strobes reaches every register. Reading a channel's status register with the read strobe clears that status.

By default, a phase lasts one cycle more than its count, so every phase is at least one cycle long. A full-range control bit makes a phase last exactly its count. A zero count then removes that phase, which gives a steady 0% or 100% output. With phase alternation off, the channel reloads only from the low-phase count and gives a square wave. In free-running mode, the all-ones value replaces both counts. The counts and the mode bits are captured when a channel is enabled. Software clears enable, rewrites the counts and sets enable again.

Top module: `dual_reload_pwm`

## Requirements
- R1: After reset every output is low, every irq is low and every register reads zero.
- R2: The word address is {channel, register}, with channel in addr[AW-1:2]. Register 0 is the low-phase count, 1 the high-phase count, 2 the control word and 3 the status (bit 0). Control bits: 0 enable, 1 user counts (0 = free-running), 2 irq mask, 3 phase alternation, 4 full range. A read returns the last value written, and reading without rd_en changes nothing.
- R3: With alternation on and full range off, an enabled channel is low for low+1 cycles and then high for high+1 cycles, and repeats. The first low phase starts in the cycle after the enabling write.
- R4: With full range on, each phase lasts exactly its count. A low count of 0 gives a constant high output and a high count of 0 gives a constant low output.
- R5: With full range and alternation on and both counts 0, the output stays low and no expiry occurs.
- R6: With alternation off, every phase reloads from the low count alone and the output toggles at each expiry. Under full range a low count of 0 holds the output low.
- R7: In free-running mode each count is taken as all ones: 2^CW cycles per phase normally and 2^CW-1 under full range.
- R8: The counts and the alternation, mode and range bits are captured while the channel is disabled. Writes made while it runs take effect only after the next re-enable.
- R9: Clearing enable drives the output low in the next cycle. The next enable starts again with a complete low phase.
- R10: Each expiry sets the channel's sticky status, which is visible on irq, unless the mask bit is set.
- R11: A read with rd_en of the status register clears it. If an expiry falls in the same cycle as that read, the status stays set.
- R12: The channels run independently, each from its own registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; its only side effect is clearing status |
| addr | input | AW | Word address {channel, register} |
| wdata | input | CW | Write data |
| rdata | output | CW | Read data, combinational from addr |
| pwm_out | output | NCH | Per-channel waveform |
| irq | output | NCH | Per-channel sticky status |

## Verification
A phase expiry and a status-clearing read can land on the same clock edge, and the status must then remain set. The bench computes the exact edge of the second expiry after enable and holds the status read across exactly that edge. It expects irq still high afterwards. It then repeats the read one cycle clear of any expiry and expects irq low until the following expiry edge, which it also predicts.

// File: rtl/dual_reload_pwm.sv
module dual_reload_pwm #(
  parameter int NCH = 3,
  parameter int CW  = 32,
  parameter int AW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic [NCH-1:0] pwm_out,
  output logic [NCH-1:0] irq
);
  localparam int CHW = AW - 2;
  localparam int CTW = 5;

  logic [NCH*CW-1:0]  lo_v, hi_v;
  logic [NCH*CTW-1:0] ctl_v;
  logic [NCH-1:0]     st_v, en_v, mask_v, exp_v, idle_v;

  function automatic logic [CW:0] phase_len(input logic [CTW-1:0] c, input logic [CW-1:0] v);
    logic [CW-1:0] n;
    n = c[1] ? v : '1;
    return c[4] ? {1'b0, n} : {1'b0, n} + 1'b1;
  endfunction

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CW-1:0]  lo_q, hi_q, lo_d, hi_d;
    logic [CTW-1:0] ctl_q, ctl_d;
    logic           st_q, tgl_q, ph_q;
    logic [CW:0]    lo_len_q, hi_len_q, rem_q, len_lo, len_hi, nxt_len, cur_len;
    logic           hit, wr_lo, wr_hi, wr_ctl, eoi, en, expire, start_hi;

    assign hit     = addr[AW-1:2] == CHW'(g);
    assign wr_lo   = wr_en && hit && addr[1:0] == 2'd0;
    assign wr_hi   = wr_en && hit && addr[1:0] == 2'd1;
    assign wr_ctl  = wr_en && hit && addr[1:0] == 2'd2;
    assign eoi     = rd_en && hit && addr[1:0] == 2'd3;

    assign lo_d    = wr_lo  ? wdata : lo_q;
    assign hi_d    = wr_hi  ? wdata : hi_q;
    assign ctl_d   = wr_ctl ? wdata[CTW-1:0] : ctl_q;
    assign len_lo  = phase_len(ctl_d, lo_d);
    assign len_hi  = phase_len(ctl_d, hi_d);
    assign start_hi = ctl_d[3] && len_lo == '0 && len_hi != '0;

    assign en      = ctl_q[0];
    assign expire  = en && rem_q == (CW+1)'(1);
    assign nxt_len = ph_q ? lo_len_q : hi_len_q;
    assign cur_len = ph_q ? hi_len_q : lo_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q  <= '0;
        hi_q  <= '0;
        ctl_q <= '0;
        st_q  <= 1'b0;
      end else begin
        lo_q  <= lo_d;
        hi_q  <= hi_d;
        ctl_q <= ctl_d;
        st_q  <= (expire && !ctl_q[2]) || (st_q && !eoi);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_len_q <= '0;
        hi_len_q <= '0;
        tgl_q    <= 1'b0;
        ph_q     <= 1'b0;
        rem_q    <= '0;
      end else if (!en) begin
        lo_len_q <= len_lo;
        hi_len_q <= len_hi;
        tgl_q    <= ctl_d[3];
        ph_q     <= start_hi;
        rem_q    <= start_hi ? len_hi : len_lo;
      end else if (expire) begin
        if (!tgl_q) begin
          ph_q  <= ~ph_q;
          rem_q <= lo_len_q;
        end else if (nxt_len != '0) begin
          ph_q  <= ~ph_q;
          rem_q <= nxt_len;
        end else begin
          rem_q <= cur_len;
        end
      end else if (rem_q != '0) begin
        rem_q <= rem_q - 1'b1;
      end
    end

    assign pwm_out[g] = en & ph_q;
    assign irq[g]     = st_q;

    assign lo_v[g*CW +: CW]    = lo_q;
    assign hi_v[g*CW +: CW]    = hi_q;
    assign ctl_v[g*CTW +: CTW] = ctl_q;
    assign st_v[g]   = st_q;
    assign en_v[g]   = en;
    assign mask_v[g] = ctl_q[2];
    assign exp_v[g]  = expire;
    assign idle_v[g] = lo_len_q == '0 && (!tgl_q || hi_len_q == '0);
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr[AW-1:2] == CHW'(i)) begin
        case (addr[1:0])
          2'd0:    rdata = lo_v[i*CW +: CW];
          2'd1:    rdata = hi_v[i*CW +: CW];
          2'd2:    rdata = CW'(ctl_v[i*CTW +: CTW]);
          default: rdata = CW'(st_v[i]);
        endcase
      end
    end
  end
endmodule

module dual_reload_pwm_chk #(
  parameter int NCH = 3,
  parameter int AW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [AW-1:0]  addr,
  input logic           wbit0,
  input logic [NCH-1:0] pwm_out,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] en_v,
  input logic [NCH-1:0] mask_v,
  input logic [NCH-1:0] exp_v,
  input logic [NCH-1:0] idle_v
);
  for (genvar g = 0; g < NCH; g++) begin : g_a
    // R9
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(g*4+2) && !wbit0) |=> !pwm_out[g]);
    // R10
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[g]) |-> !$past(mask_v[g]));
    // R5
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_v[g] && idle_v[g]) |-> !pwm_out[g]);
    // R3
    edge_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_v[g] && $past(en_v[g]) && pwm_out[g] != $past(pwm_out[g])) |-> $past(exp_v[g]));
  end
endmodule

bind dual_reload_pwm dual_reload_pwm_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wbit0(wdata[0]),
  .pwm_out(pwm_out), .irq(irq), .en_v(en_v), .mask_v(mask_v),
  .exp_v(exp_v), .idle_v(idle_v)
);

// File: tb/dual_reload_pwm_tb.sv
`timescale 1ns/1ps
module dual_reload_pwm_tb;
  localparam int NCH = 3, CW = 8, AW = 4;
  localparam int EN = 1, USR = 2, MSK = 4, ALT = 8, FULL = 16;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [CW-1:0] wdata = '0;
  logic [CW-1:0] rdata;
  logic [NCH-1:0] pwm_out, irq;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  dual_reload_pwm #(.NCH(NCH), .CW(CW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .irq(irq));

  task automatic check(int act, int exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; addr = AW'(a); wdata = CW'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic eoi(int ch);
    @(negedge clk); rd_en = 1; addr = AW'(ch*4+3);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic peek(int a, int exp, string tag);
    addr = AW'(a); #1;
    check(int'(rdata), exp, tag);
  endtask

  function automatic int model(int k, int ll, int lh, bit alt);
    if (!alt) return (ll == 0) ? 0 : (k / ll) % 2;
    if (ll + lh == 0) return 0;
    return ((k % (ll + lh)) >= ll) ? 1 : 0;
  endfunction

  task automatic cfg(int ch, int lo, int hi, int ctl, output int base);
    wr(ch*4+2, 0);
    wr(ch*4+0, lo);
    wr(ch*4+1, hi);
    wr(ch*4+2, ctl);
    base = cyc;
  endtask

  task automatic run(int ch, int base, int ll, int lh, bit alt, int n, string tag);
    for (int i = 0; i < n; i++) begin
      check(int'(pwm_out[ch]), model(cyc - base, ll, lh, alt), tag);
      @(negedge clk);
    end
  endtask

  task automatic wait_k(int base, int k);
    while (cyc - base < k) @(negedge clk);
  endtask

  initial begin
    #3000000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int b, b2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(int'(pwm_out), 0, "R1 out");
    check(int'(irq), 0, "R1 irq");
    for (int a = 0; a < 12; a++) peek(a, 0, "R1 reg");

    // R2 readback
    wr(2*4+0, 'hA5); wr(2*4+1, 'h3C); wr(2*4+2, 'h1E);
    peek(2*4+0, 'hA5, "R2 lo"); peek(2*4+1, 'h3C, "R2 hi"); peek(2*4+2, 'h1E, "R2 ctl");
    peek(1*4+0, 0, "R2 other ch");

    // R3 / R4 sweep across channels and counts
    for (int ch = 0; ch < NCH; ch++)
      for (int lo = 0; lo < 4; lo++)
        for (int hi = 0; hi < 4; hi++)
          for (int f = 0; f < 2; f++) begin
            int ll, lh;
            ll = f ? lo : lo + 1;
            lh = f ? hi : hi + 1;
            cfg(ch, lo, hi, EN | USR | ALT | (f ? FULL : 0), b);
            run(ch, b, ll, lh, 1, 2*(ll+lh)+2, f ? "R4 full sweep" : "R3 normal sweep");
          end

    // R5 both zero full range
    cfg(0, 0, 0, 0, b); eoi(0);
    wr(2, EN | USR | ALT | FULL); b = cyc;
    for (int i = 0; i < 12; i++) begin
      check(int'(pwm_out[0]), 0, "R5 out");
      check(int'(irq[0]), 0, "R5 irq");
      @(negedge clk);
    end

    // R6 alternation off
    cfg(1, 2, 5, EN | USR, b);        run(1, b, 3, 0, 0, 14, "R6 normal");
    cfg(1, 3, 1, EN | USR | FULL, b); run(1, b, 3, 0, 0, 14, "R6 full");
    cfg(1, 0, 4, EN | USR | FULL, b); run(1, b, 0, 0, 0, 8, "R6 zero");

    // R7 free-running
    cfg(0, 1, 1, EN | ALT, b);        run(0, b, 256, 256, 1, 520, "R7 normal");
    cfg(0, 1, 1, EN | ALT | FULL, b); run(0, b, 255, 255, 1, 515, "R7 full");

    // R8 writes while running are ignored until re-enable
    cfg(0, 1, 2, EN | USR | ALT, b);
    run(0, b, 2, 3, 1, 5, "R8 before");
    wr(0, 6);
    wr(2, EN | USR | ALT | FULL);
    run(0, b, 2, 3, 1, 12, "R8 ignored");
    peek(0, 6, "R8 readback");
    wr(2, USR | ALT);
    wr(2, EN | USR | ALT); b = cyc;
    run(0, b, 7, 3, 1, 22, "R8 new");

    // R9 disable and restart
    wr(2, 0);
    for (int i = 0; i < 3; i++) begin
      check(int'(pwm_out[0]), 0, "R9 off");
      @(negedge clk);
    end
    wr(2, EN | USR | ALT); b = cyc;
    run(0, b, 7, 3, 1, 12, "R9 restart");

    // R10 / R11 status set, clear and coincidence
    cfg(1, 2, 3, 0, b); eoi(1);
    check(int'(irq[1]), 0, "R11 cleared");
    wr(6, EN | USR | ALT); b = cyc;
    for (int k = 0; k < 3; k++) begin
      check(int'(irq[1]), 0, "R10 before expiry");
      @(negedge clk);
    end
    check(int'(irq[1]), 1, "R10 first expiry");
    @(negedge clk);
    peek(7, 1, "R10 status read");
    wait_k(b, 6);
    rd_en = 1; addr = AW'(7);
    @(negedge clk); rd_en = 0;
    check(int'(irq[1]), 1, "R11 set wins");
    rd_en = 1;
    @(negedge clk); rd_en = 0;
    check(int'(irq[1]), 0, "R11 clear");
    @(negedge clk);
    check(int'(irq[1]), 0, "R11 stays clear");
    @(negedge clk);
    check(int'(irq[1]), 1, "R10 next expiry");

    // R10 mask
    cfg(2, 0, 0, 0, b); eoi(2);
    wr(10, EN | USR | ALT | MSK); b = cyc;
    for (int i = 0; i < 10; i++) begin
      check(int'(irq[2]), 0, "R10 masked");
      check(int'(pwm_out[2]), model(cyc - b, 1, 1, 1), "R10 masked out");
      @(negedge clk);
    end

    // R12 independent channels
    wr(2, 0);
    cfg(1, 1, 1, EN | USR | ALT, b);
    cfg(2, 2, 1, EN | USR | ALT | FULL, b2);
    for (int i = 0; i < 20; i++) begin
      check(int'(pwm_out[1]), model(cyc - b, 2, 2, 1), "R12 ch1");
      check(int'(pwm_out[2]), model(cyc - b2, 2, 1, 1), "R12 ch2");
      check(int'(pwm_out[0]), 0, "R12 ch0 idle");
      @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule